// File: doc/BRIEF.md
# Accumulator ALU with Condition Flags

This block is the arithmetic and logic stage of an accumulator-based 8-bit processor. Each cycle it receives a 3-bit operation select, the accumulator, a second operand and the current flag byte. It produces the operation result, a write-enable that tells the register stage whether to store that result, and the updated flag byte. The operation set covers add, add with carry, subtract, subtract with borrow, AND, XOR, OR and compare. A separate test input requests a non-storing AND that only updates the flags.

Each operation class updates half-carry, parity/overflow, subtract and carry by its own rule. The two arithmetic groups report signed overflow in the P/V flag. The logic group reports even parity there. Compare and test behave like subtract and AND, but never request a write. The outputs are registered, so a result appears one clock after its operands. Operand fetch, the register file and memory access are handled elsewhere.

Top module: `alu8_core`

## Requirements
- R1: `op_sel` chooses the operation: 000 add, 001 add with carry, 010 subtract, 011 subtract with borrow, 100 AND, 101 XOR, 110 OR, 111 compare.
- R2: Add and add-with-carry produce the sum modulo 256. H is the carry out of bit 3, P/V (bit 2) is signed overflow, N (bit 1) is cleared, and C (bit 0) is the carry out of bit 7.
- R3: Subtract, subtract-with-borrow and compare produce A minus operand. H is the borrow out of bit 3, P/V is signed overflow, N is set, and C is the borrow out of bit 7.
- R4: The incoming carry (`flags_in` bit 0) feeds the sum, the half-carry and the overflow only for add-with-carry and subtract-with-borrow. For every other operation it has no effect.
- R5: AND sets H (bit 4), clears N and C, and sets P/V when the result holds an even number of ones.
- R6: XOR and OR clear H, N and C, and set P/V when the result holds an even number of ones.
- R7: Compare drives `res_we` low. Every other operation selected through `op_sel` drives it high.
- R8: While `test_en` is high, `op_sel` is ignored. The block computes A AND operand with the AND flags of R5 and drives `res_we` low.
- R9: S (bit 7) copies bit 7 of the result, and Z (bit 6) is set exactly when the 8-bit result is zero.
- R10: Flag bits 5 and 3 pass from `flags_in` to `flags_out` unchanged.
- R11: Outputs are registered. Operands applied before a rising edge show their result after that edge. While `rst_n` is low, the result, the write-enable and the flags are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_sel | input | 3 | Operation select (R1 encoding) |
| test_en | input | 1 | Non-storing AND test, overrides op_sel |
| acc_in | input | 8 | Accumulator operand |
| opnd_in | input | 8 | Second operand |
| flags_in | input | 8 | Current flag byte (S Z - H - P/V N C) |
| result | output | 8 | Registered result |
| res_we | output | 1 | Result write-enable |
| flags_out | output | 8 | Registered updated flag byte |

## Verification
The assertions assume that every input is a known value at each rising edge after reset, and they compare outputs against the inputs of the previous cycle. They also assume the reset is held for at least one edge. To stay within these assumptions, the bench drives every input to a defined value at time zero and only changes inputs on falling edges. It holds reset across several edges and sets the flag byte explicitly in every vector. That way the pass-through bits and the carry-in are always defined.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    typedef enum logic [2:0] {
        OP_ADD = 3'b000,
        OP_ADC = 3'b001,
        OP_SUB = 3'b010,
        OP_SBC = 3'b011,
        OP_AND = 3'b100,
        OP_XOR = 3'b101,
        OP_OR  = 3'b110,
        OP_CMP = 3'b111
    } alu_op_e;

    typedef enum logic [1:0] {
        LG_AND = 2'b00,
        LG_XOR = 2'b01,
        LG_OR  = 2'b10
    } logic_sel_e;

    localparam int FLAG_W   = 8;
    localparam int FB_SIGN  = 7;
    localparam int FB_ZERO  = 6;
    localparam int FB_HALF  = 4;
    localparam int FB_PV    = 2;
    localparam int FB_NEG   = 1;
    localparam int FB_CARRY = 0;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
    parameter int DATA_W = 8,
    parameter int HALF_B = 4
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    input  logic              sub,
    output logic [DATA_W-1:0] sum,
    output logic              carry,
    output logic              half,
    output logic              ovf
);
    localparam int LO_W = HALF_B + 1;
    localparam int HI_W = DATA_W + 1;

    logic [LO_W-1:0] lo_d;
    logic [HI_W-1:0] full_d;

    always_comb begin
        if (sub) begin
            lo_d   = {1'b0, a[HALF_B-1:0]} - {1'b0, b[HALF_B-1:0]} - {{HALF_B{1'b0}}, cin};
            full_d = {1'b0, a} - {1'b0, b} - {{DATA_W{1'b0}}, cin};
        end else begin
            lo_d   = {1'b0, a[HALF_B-1:0]} + {1'b0, b[HALF_B-1:0]} + {{HALF_B{1'b0}}, cin};
            full_d = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin};
        end
        sum   = full_d[DATA_W-1:0];
        carry = full_d[DATA_W];
        half  = lo_d[HALF_B];
        if (sub) begin
            ovf = (a[DATA_W-1] != b[DATA_W-1]) && (sum[DATA_W-1] != a[DATA_W-1]);
        end else begin
            ovf = (a[DATA_W-1] == b[DATA_W-1]) && (sum[DATA_W-1] != a[DATA_W-1]);
        end
    end

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic_sel_e        sel,
    output logic [DATA_W-1:0] y,
    output logic              par_even
);
    logic [DATA_W-1:0] ones_d;

    always_comb begin
        unique case (sel)
            LG_AND:  y = a & b;
            LG_XOR:  y = a ^ b;
            LG_OR:   y = a | b;
            default: y = a & b;
        endcase
    end

    generate
        for (genvar gi = 0; gi < DATA_W; gi++) begin : g_par
            if (gi == 0) begin : g_first
                assign ones_d[gi] = y[gi];
            end else begin : g_rest
                assign ones_d[gi] = ones_d[gi-1] ^ y[gi];
            end
        end
    endgenerate

    assign par_even = ~ones_d[DATA_W-1];

endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int HALF_B = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        op_sel,
    input  logic              test_en,
    input  logic [DATA_W-1:0] acc_in,
    input  logic [DATA_W-1:0] opnd_in,
    input  logic [FLAG_W-1:0] flags_in,
    output logic [DATA_W-1:0] result,
    output logic              res_we,
    output logic [FLAG_W-1:0] flags_out
);
    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              we;
        logic [FLAG_W-1:0] flags;
    } alu_out_t;

    alu_op_e           op_d;
    logic              is_arith_d;
    logic              is_sub_d;
    logic              use_cin_d;
    logic_sel_e        lsel_d;
    logic [DATA_W-1:0] sum_d;
    logic              carry_d;
    logic              half_d;
    logic              ovf_d;
    logic [DATA_W-1:0] lg_d;
    logic              par_d;
    alu_out_t          out_d;
    alu_out_t          out_q;

    always_comb begin
        op_d       = alu_op_e'(op_sel);
        is_arith_d = !test_en && !op_sel[2];
        is_sub_d   = (op_d == OP_SUB) || (op_d == OP_SBC) || (op_d == OP_CMP);
        use_cin_d  = (op_d == OP_ADC) || (op_d == OP_SBC);
        if (test_en) begin
            lsel_d = LG_AND;
        end else begin
            unique case (op_d)
                OP_XOR:  lsel_d = LG_XOR;
                OP_OR:   lsel_d = LG_OR;
                default: lsel_d = LG_AND;
            endcase
        end
    end

    alu8_addsub #(
        .DATA_W (DATA_W),
        .HALF_B (HALF_B)
    ) i_addsub (
        .a     (acc_in),
        .b     (opnd_in),
        .cin   (use_cin_d & flags_in[FB_CARRY]),
        .sub   (is_sub_d),
        .sum   (sum_d),
        .carry (carry_d),
        .half  (half_d),
        .ovf   (ovf_d)
    );

    alu8_logic #(
        .DATA_W (DATA_W)
    ) i_logic (
        .a        (acc_in),
        .b        (opnd_in),
        .sel      (lsel_d),
        .y        (lg_d),
        .par_even (par_d)
    );

    always_comb begin
        out_d = '0;
        out_d.flags = flags_in;
        if (test_en || op_sel[2] && (op_d != OP_CMP)) begin
            out_d.res              = lg_d;
            out_d.flags[FB_HALF]   = (lsel_d == LG_AND);
            out_d.flags[FB_PV]     = par_d;
            out_d.flags[FB_NEG]    = 1'b0;
            out_d.flags[FB_CARRY]  = 1'b0;
        end else begin
            out_d.res              = sum_d;
            out_d.flags[FB_HALF]   = half_d;
            out_d.flags[FB_PV]     = ovf_d;
            out_d.flags[FB_NEG]    = is_sub_d;
            out_d.flags[FB_CARRY]  = carry_d;
        end
        out_d.flags[FB_SIGN] = out_d.res[DATA_W-1];
        out_d.flags[FB_ZERO] = (out_d.res == '0);
        out_d.we = !test_en && (op_d != OP_CMP);
        if (is_arith_d && !is_sub_d) begin
            out_d.flags[FB_NEG] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign result    = out_q.res;
    assign res_we    = out_q.we;
    assign flags_out = out_q.flags;

endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        op_sel,
    input logic              test_en,
    input logic [DATA_W-1:0] acc_in,
    input logic [DATA_W-1:0] opnd_in,
    input logic [FLAG_W-1:0] flags_in,
    input logic [DATA_W-1:0] result,
    input logic              res_we,
    input logic [FLAG_W-1:0] flags_out
);

    // R7: compare never requests a write
    a_r7_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!test_en && op_sel == 3'b111) |=> !res_we);

    // R8: test operation never requests a write
    a_r8_test_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        test_en |=> !res_we);

    // R3: subtract class sets N
    a_r3_sub_sets_n: assert property (@(posedge clk) disable iff (!rst_n)
        (!test_en && (op_sel == 3'b010 || op_sel == 3'b011 || op_sel == 3'b111))
        |=> flags_out[FB_NEG]);

    // R2: add class clears N
    a_r2_add_clears_n: assert property (@(posedge clk) disable iff (!rst_n)
        (!test_en && (op_sel == 3'b000 || op_sel == 3'b001)) |=> !flags_out[FB_NEG]);

    // R5 / R6: logic class clears N and C
    a_r6_logic_clears_nc: assert property (@(posedge clk) disable iff (!rst_n)
        (test_en || (op_sel[2] && op_sel != 3'b111))
        |=> (!flags_out[FB_NEG] && !flags_out[FB_CARRY]));

    // R5: AND and test set H
    a_r5_and_sets_h: assert property (@(posedge clk) disable iff (!rst_n)
        (test_en || op_sel == 3'b100) |=> flags_out[FB_HALF]);

    // R10: unused flag bits pass through
    a_r10_pass_bits: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (flags_out[5] == $past(flags_in[5]) && flags_out[3] == $past(flags_in[3])));

    // R9: zero and sign track the registered result
    a_r9_zero_sign: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (flags_out[FB_ZERO] == (result == '0) &&
                  flags_out[FB_SIGN] == result[DATA_W-1]));

    // R11: outputs are zero while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_r11_reset_zero: assert (result == '0 && !res_we && flags_out == '0);
        end
    end

endmodule

bind alu8_core alu8_core_chk #(
    .DATA_W (DATA_W)
) i_alu8_core_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_sel    (op_sel),
    .test_en   (test_en),
    .acc_in    (acc_in),
    .opnd_in   (opnd_in),
    .flags_in  (flags_in),
    .result    (result),
    .res_we    (res_we),
    .flags_out (flags_out)
);

// File: tb/test_alu8_core.sv
`timescale 1ns/100ps
module test_alu8_core;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] op_sel = 3'b000;
    logic       test_en = 1'b0;
    logic [7:0] acc_in = 8'h00;
    logic [7:0] opnd_in = 8'h00;
    logic [7:0] flags_in = 8'h00;
    logic [7:0] result;
    logic       res_we;
    logic [7:0] flags_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    alu8_core i_alu8_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_sel    (op_sel),
        .test_en   (test_en),
        .acc_in    (acc_in),
        .opnd_in   (opnd_in),
        .flags_in  (flags_in),
        .result    (result),
        .res_we    (res_we),
        .flags_out (flags_out)
    );

    // stimulus vector: {test, op[2:0], a, b, flags_in}
    localparam int NV = 20;
    localparam logic [27:0] VEC [NV] = '{
        {1'b0, 3'd0, 8'h7F, 8'h01, 8'h00},
        {1'b0, 3'd0, 8'h80, 8'h80, 8'h01},
        {1'b0, 3'd1, 8'hFF, 8'h00, 8'h01},
        {1'b0, 3'd1, 8'h0E, 8'h01, 8'h29},
        {1'b0, 3'd2, 8'h00, 8'h01, 8'h00},
        {1'b0, 3'd2, 8'h80, 8'h01, 8'h01},
        {1'b0, 3'd3, 8'h80, 8'h00, 8'h01},
        {1'b0, 3'd3, 8'h10, 8'h0F, 8'h00},
        {1'b0, 3'd4, 8'hF0, 8'h0F, 8'hFF},
        {1'b0, 3'd4, 8'hC3, 8'h81, 8'h00},
        {1'b0, 3'd5, 8'hFF, 8'h01, 8'h00},
        {1'b0, 3'd5, 8'h5A, 8'h5A, 8'h17},
        {1'b0, 3'd6, 8'h03, 8'h00, 8'h28},
        {1'b0, 3'd6, 8'h80, 8'h40, 8'h01},
        {1'b0, 3'd7, 8'h42, 8'h42, 8'h00},
        {1'b0, 3'd7, 8'h10, 8'h20, 8'h01},
        {1'b1, 3'd0, 8'h81, 8'hFF, 8'h01},
        {1'b1, 3'd6, 8'h0F, 8'hF0, 8'h08},
        {1'b1, 3'd7, 8'h07, 8'h03, 8'h20},
        {1'b0, 3'd2, 8'h7F, 8'hFF, 8'h00}
    };

    function automatic logic [16:0] ref_model(input logic t, input logic [2:0] op,
                                              input logic [7:0] a, input logic [7:0] b,
                                              input logic [7:0] fi);
        int r, c, lo, sa, sb, sf;
        logic [7:0] fl, res;
        logic we;
        fl = fi;
        fl[7] = 1'b0; fl[6] = 1'b0; fl[4] = 1'b0; fl[2] = 1'b0; fl[1] = 1'b0; fl[0] = 1'b0;
        sa = (a > 127) ? int'(a) - 256 : int'(a);
        sb = (b > 127) ? int'(b) - 256 : int'(b);
        if (t || op == 3'd4 || op == 3'd5 || op == 3'd6) begin
            if (t || op == 3'd4) res = a & b;
            else if (op == 3'd5) res = a ^ b;
            else res = a | b;
            fl[4] = (t || op == 3'd4);
            fl[2] = ($countones(res) % 2) == 0;
        end else begin
            c = (op == 3'd1 || op == 3'd3) ? int'(fi[0]) : 0;
            if (op == 3'd0 || op == 3'd1) begin
                r  = int'(a) + int'(b) + c;
                lo = int'(a[3:0]) + int'(b[3:0]) + c;
                sf = sa + sb + c;
                fl[0] = r > 255;
                fl[4] = lo > 15;
            end else begin
                r  = int'(a) - int'(b) - c;
                lo = int'(a[3:0]) - int'(b[3:0]) - c;
                sf = sa - sb - c;
                fl[0] = r < 0;
                fl[4] = lo < 0;
                fl[1] = 1'b1;
            end
            res = 8'(r);
            fl[2] = (sf > 127) || (sf < -128);
        end
        fl[7] = res[7];
        fl[6] = (res == 8'h00);
        we = !t && (op != 3'd7);
        return {res, we, fl};
    endfunction

    task automatic check(input string req, input logic [16:0] act, input logic [16:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: got res=%02h we=%0b flags=%02h, expected res=%02h we=%0b flags=%02h",
                     req, act[16:9], act[8], act[7:0], exp[16:9], exp[8], exp[7:0]);
        end
    endtask

    task automatic apply(input logic t, input logic [2:0] op, input logic [7:0] a,
                         input logic [7:0] b, input logic [7:0] fi);
        test_en = t; op_sel = op; acc_in = a; opnd_in = b; flags_in = fi;
        @(negedge clk);
    endtask

    function automatic string req_of(input logic t, input logic [2:0] op);
        if (t) return "R8";
        case (op)
            3'd0, 3'd1: return "R2";
            3'd2, 3'd3: return "R3";
            3'd4:       return "R5";
            3'd5, 3'd6: return "R6";
            default:    return "R7";
        endcase
    endfunction

    initial begin
        #(200000 * 5);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R11: reset state
        flags_in = 8'hFF; acc_in = 8'h7F; opnd_in = 8'h01;
        repeat (3) @(negedge clk);
        check("R11 reset", {result, res_we, flags_out}, 17'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk (R1, R9 and R10 through the reference model)
        for (int i = 0; i < NV; i++) begin
            logic [27:0] v;
            v = VEC[i];
            apply(v[27], v[26:24], v[23:16], v[15:8], v[7:0]);
            check({req_of(v[27], v[26:24]), " R1 R9 R10 vec"}, {result, res_we, flags_out},
                  ref_model(v[27], v[26:24], v[23:16], v[15:8], v[7:0]));
        end

        // directed corners, hand-derived
        apply(1'b0, 3'd0, 8'h7F, 8'h01, 8'h00);
        check("R2 add overflow", {result, res_we, flags_out}, {8'h80, 1'b1, 8'h94});
        apply(1'b0, 3'd2, 8'h00, 8'h01, 8'h00);
        check("R3 sub borrow", {result, res_we, flags_out}, {8'hFF, 1'b1, 8'h93});
        apply(1'b0, 3'd1, 8'hFF, 8'h00, 8'h01);
        check("R4 R9 adc carry-in zero", {result, res_we, flags_out}, {8'h00, 1'b1, 8'h51});
        apply(1'b0, 3'd3, 8'h80, 8'h00, 8'h01);
        check("R4 sbc borrow-in overflow", {result, res_we, flags_out}, {8'h7F, 1'b1, 8'h16});
        apply(1'b0, 3'd0, 8'h01, 8'h01, 8'h01);
        check("R4 add ignores carry", {result, res_we, flags_out}, {8'h02, 1'b1, 8'h00});
        apply(1'b0, 3'd2, 8'h05, 8'h01, 8'h01);
        check("R4 sub ignores carry", {result, res_we, flags_out}, {8'h04, 1'b1, 8'h02});
        apply(1'b0, 3'd7, 8'h42, 8'h42, 8'h00);
        check("R7 compare equal", {result, res_we, flags_out}, {8'h00, 1'b0, 8'h42});
        apply(1'b0, 3'd4, 8'hF0, 8'h0F, 8'h00);
        check("R5 and zero", {result, res_we, flags_out}, {8'h00, 1'b1, 8'h54});
        apply(1'b0, 3'd5, 8'hFF, 8'h01, 8'h00);
        check("R6 xor odd parity", {result, res_we, flags_out}, {8'hFE, 1'b1, 8'h80});
        apply(1'b0, 3'd6, 8'h03, 8'h00, 8'h28);
        check("R6 R10 or passthrough", {result, res_we, flags_out}, {8'h03, 1'b1, 8'h2C});
        apply(1'b1, 3'd0, 8'h81, 8'hFF, 8'h00);
        check("R8 test overrides add", {result, res_we, flags_out}, {8'h81, 1'b0, 8'h94});

        // R11: latency, output holds previous result until the next edge
        test_en = 1'b0; op_sel = 3'd0; acc_in = 8'h10; opnd_in = 8'h20; flags_in = 8'h00;
        #1;
        check("R11 registered hold", {result, res_we, flags_out}, {8'h81, 1'b0, 8'h94});
        @(negedge clk);
        check("R11 one-cycle update", {result, res_we, flags_out}, {8'h30, 1'b1, 8'h00});

        // R11: asynchronous reset clears outputs
        rst_n = 1'b0;
        #1;
        check("R11 async reset", {result, res_we, flags_out}, 17'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule